// File: doc/BRIEF.md
# Transmit Cell FIFO Manager

This block buffers transmit cells between an ATM-layer master and a downstream cell consumer, all on one clock. The master presents one bus word per cycle on `tx_data` with `tx_en`, and flags the first word of each cell with `tx_soc`. A cell is 53 bytes. That is 53 words on an 8-bit bus, or 27 words on a 16-bit bus, where the last word carries one padding byte. The block writes each word at a speculative (shadow) position. The cell becomes visible to the reader only when its final word arrives. At that point the committed write boundary moves forward by a whole cell.

Cells that end too early, and cells that collide with a full buffer, are rolled back to the last committed boundary. A full buffer also sets a sticky overrun interrupt flag. Flow control to the master comes from `tx_clav`, which runs in one of two modes. In word-level mode it drops when four or fewer writes remain. In cell-level mode it stays high only while a further whole cell fits. A small configuration register selects the mode and the working depth (2, 4, 8 or 16 cells). Writing that register empties the buffer, and `fifo_clr` empties it on demand.

Top module: `txcell_fifo_top`

## Requirements
- R1: After reset the buffer is empty (`rd_valid`=0), `irq_ovr`=0 and `tx_clav`=1. The handshake mode is cell-level and the depth code is 3 (16 cells).
- R2: A cycle with `cfg_we`=1 loads `cfg_hs_mode` (0 = word-level, 1 = cell-level) and `cfg_depth` (code n selects 2<<n cells). The same cycle discards all stored and partial data.
- R3: A word accepted with `tx_en`=1 and `tx_soc`=1 opens a cell. A cell holds CELL_WORDS words (53 at 8 bits, 27 at 16 bits). Words with `tx_en`=1 and `tx_soc`=0 while no cell is open are ignored.
- R4: No word of a cell is visible to the reader before its last word has been written. `rd_valid` rises in the cycle after that last write.
- R5: The reader receives committed words in write order. `rd_data` is valid while `rd_valid`=1, and `rd_en`=1 consumes one word. `rd_sop`=1 marks the first word of each cell.
- R6: A start-of-cell word that arrives while a cell is open discards the open cell's words (a runt). The new cell is then stored normally.
- R7: A write attempted while no free word remains (words of the open cell count as used) is an overrun. It sets `irq_ovr` and discards the open cell. Words are then ignored until the next start-of-cell. Committed cells are kept.
- R8: `irq_ovr` stays set until a cycle with `irq_clr`=1 and no new overrun.
- R9: In word-level mode, `tx_clav`=1 exactly when more than four words are free, counting open-cell words as used. It returns high once reads free that space.
- R10: In cell-level mode, `tx_clav`=1 exactly when a whole free cell remains after a whole cell is reserved for any open cell.
- R11: `fifo_clr`=1 empties the buffer and drops the open cell. It leaves the configuration and `irq_ovr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load configuration and flush |
| cfg_hs_mode | input | 1 | Handshake mode: 0 word-level, 1 cell-level |
| cfg_depth | input | 2 | Depth code, 2<<code cells |
| fifo_clr | input | 1 | Flush buffer contents |
| tx_en | input | 1 | Write strobe from master |
| tx_soc | input | 1 | First word of cell |
| tx_data | input | DATA_W | Write data |
| tx_clav | output | 1 | Space-available flow control |
| irq_clr | input | 1 | Clear overrun flag |
| irq_ovr | output | 1 | Sticky overrun flag |
| rd_en | input | 1 | Consume one word |
| rd_valid | output | 1 | Committed word present |
| rd_sop | output | 1 | Presented word starts a cell |
| rd_data | output | DATA_W | Presented word |

## Verification
The assertions assume a master that obeys `tx_clav` in normal traffic. On that basis a write seen while `tx_clav` is high must never turn into an overrun. They also assume that a flush or configuration write is a single-cycle pulse with no read in the same cycle. The stimulus keeps to these limits. Overruns come only from a deliberate start-of-cell after the buffer is full. Reads are held off whenever fill levels are measured, and flush pulses are placed in idle cycles.

// File: rtl/txcell_pkg.sv
// Shared constants and types for the transmit cell FIFO manager.
// Assumes depth codes select 2<<code cells, so the code width fixes the maximum depth.
package txcell_pkg;
    localparam int DEPTH_SEL_W     = 2;
    localparam int MAX_CELLS       = 2 << ((1 << DEPTH_SEL_W) - 1);
    localparam int CELL_BYTES      = 53;
    localparam int OCTET_LOW_WRITES = 4;

    typedef enum logic {HS_OCTET = 1'b0, HS_CELL = 1'b1} hs_mode_e;

    // Words per cell for a given bus width (last word padded when needed).
    function automatic int cell_words(input int data_w);
        return (CELL_BYTES + (data_w / 8) - 1) / (data_w / 8);
    endfunction
endpackage

// File: rtl/txcell_cfg.sv
// Configuration register: handshake mode and depth code, plus derived capacity.
// Assumes a load is a one-cycle pulse; the top uses the same pulse as a flush.
module txcell_cfg
    import txcell_pkg::*;
#(
    parameter int CELL_WORDS = 53,
    parameter int CNT_W      = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic                   cfg_hs_mode,
    input  logic [DEPTH_SEL_W-1:0] cfg_depth,
    output hs_mode_e               mode_o,
    output logic [CNT_W-1:0]       cap_o
);
    logic [DEPTH_SEL_W-1:0] depth_q;

    // Hold the settings; reset selects cell-level mode and the largest depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o  <= HS_CELL;
            depth_q <= '1;
        end else if (cfg_we) begin
            mode_o  <= hs_mode_e'(cfg_hs_mode);
            depth_q <= cfg_depth;
        end
    end

    // Capacity in words: two cells shifted by the depth code.
    always_comb cap_o = CNT_W'(2 * CELL_WORDS) << depth_q;
endmodule

// File: rtl/txcell_writer.sv
// Write-side control: shadow pointer, cell framing, commit, runt and overrun rollback.
// Assumes used_i counts committed words and cap_i is the active capacity in words.
module txcell_writer #(
    parameter int CELL_WORDS = 53,
    parameter int CNT_W      = 10,
    parameter int PEND_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              tx_en,
    input  logic              tx_soc,
    input  logic              irq_clr,
    input  logic [CNT_W-1:0]  cap_i,
    input  logic [CNT_W-1:0]  used_i,
    output logic              we_o,
    output logic [CNT_W-1:0]  waddr_o,
    output logic              commit_o,
    output logic              ovr_o,
    output logic [PEND_W-1:0] pend_o,
    output logic              irq_o
);
    logic [CNT_W-1:0]  base_q, ptr_q, from_ptr, nptr, free_w;
    logic [PEND_W-1:0] cnt;
    logic              open_q, start, cont, act, last, runt_evt;

    // Decide what this cycle's write does, starting from the committed or shadow point.
    always_comb begin
        start    = tx_en && tx_soc;
        cont     = tx_en && !tx_soc && open_q;
        act      = start || cont;
        runt_evt = start && open_q;
        cnt      = start ? '0 : pend_o;
        from_ptr = start ? base_q : ptr_q;
        free_w   = cap_i - used_i - CNT_W'(cnt);
        ovr_o    = act && (free_w == '0);
        we_o     = act && !ovr_o;
        last     = (cnt == PEND_W'(CELL_WORDS - 1));
        nptr     = (from_ptr == cap_i - 1'b1) ? '0 : from_ptr + 1'b1;
        commit_o = we_o && last;
        waddr_o  = from_ptr;
    end

    // Advance or rewind the shadow pointer; move the committed boundary on a full cell.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            base_q <= '0;
            ptr_q  <= '0;
            pend_o <= '0;
            open_q <= 1'b0;
        end else if (ovr_o) begin
            ptr_q  <= base_q;
            pend_o <= '0;
            open_q <= 1'b0;
        end else if (we_o) begin
            ptr_q <= nptr;
            if (last) begin
                base_q <= nptr;
                pend_o <= '0;
                open_q <= 1'b0;
            end else begin
                pend_o <= cnt + 1'b1;
                open_q <= 1'b1;
            end
        end
    end

    // Sticky overrun flag; a new overrun wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_o <= 1'b0;
        else if (ovr_o)   irq_o <= 1'b1;
        else if (irq_clr) irq_o <= 1'b0;
    end

    // R7
    ovr_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |=> irq_o);
    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr) |=> irq_o);
    // R6
    runt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (runt_evt && !ovr_o && !flush_i && !last) |=> (pend_o == PEND_W'(1)));
endmodule

// File: rtl/txcell_store.sv
// Cell storage and read side: word memory, read pointer, committed occupancy.
// Assumes writes land only in free space and commits arrive one whole cell at a time.
module txcell_store #(
    parameter int DATA_W     = 8,
    parameter int CELL_WORDS = 53,
    parameter int MEM_WORDS  = 848,
    parameter int CNT_W      = 10,
    parameter int PTR_W      = 10,
    parameter int PEND_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [CNT_W-1:0]  cap_i,
    input  logic              we_i,
    input  logic [CNT_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              commit_i,
    input  logic              rd_en,
    output logic [CNT_W-1:0]  used_o,
    output logic              rd_valid,
    output logic              rd_sop,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [MEM_WORDS];
    logic [CNT_W-1:0]  rptr_q;
    logic [PEND_W-1:0] rcnt_q;
    logic              pop;

    // Word storage, written at the shadow address.
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i[PTR_W-1:0]] <= wdata_i;
    end

    // Present the head word of committed data.
    always_comb begin
        rd_valid = (used_o != '0);
        rd_sop   = rd_valid && (rcnt_q == '0);
        rd_data  = mem[rptr_q[PTR_W-1:0]];
        pop      = rd_en && rd_valid;
    end

    // Track the read position, the word index within the cell and the committed count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            rptr_q <= '0;
            rcnt_q <= '0;
            used_o <= '0;
        end else begin
            if (pop) begin
                rptr_q <= (rptr_q == cap_i - 1'b1) ? '0 : rptr_q + 1'b1;
                rcnt_q <= (rcnt_q == PEND_W'(CELL_WORDS - 1)) ? '0 : rcnt_q + 1'b1;
            end
            used_o <= used_o + (commit_i ? CNT_W'(CELL_WORDS) : '0) - CNT_W'(pop);
        end
    end

    // R4
    whole_cell_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (used_o > $past(used_o)) |->
        ((used_o - $past(used_o) == CNT_W'(CELL_WORDS)) ||
         (used_o - $past(used_o) == CNT_W'(CELL_WORDS - 1))));
    // R11
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !rd_valid);
endmodule

// File: rtl/txcell_fifo_top.sv
// Transmit cell FIFO manager top: configuration, writer, store and space-available output.
// Assumes one clock domain; tx_clav is derived from registered state only.
module txcell_fifo_top
    import txcell_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic                   cfg_hs_mode,
    input  logic [DEPTH_SEL_W-1:0] cfg_depth,
    input  logic                   fifo_clr,
    input  logic                   tx_en,
    input  logic                   tx_soc,
    input  logic [DATA_W-1:0]      tx_data,
    output logic                   tx_clav,
    input  logic                   irq_clr,
    output logic                   irq_ovr,
    input  logic                   rd_en,
    output logic                   rd_valid,
    output logic                   rd_sop,
    output logic [DATA_W-1:0]      rd_data
);
    localparam int CELL_WORDS = cell_words(DATA_W);
    localparam int MEM_WORDS  = MAX_CELLS * CELL_WORDS;
    localparam int PTR_W      = $clog2(MEM_WORDS);
    localparam int CNT_W      = $clog2(MEM_WORDS + 1);
    localparam int PEND_W     = $clog2(CELL_WORDS + 1);

    hs_mode_e          mode;
    logic [CNT_W-1:0]  cap, used, waddr, free_w;
    logic [CNT_W:0]    resv;
    logic [PEND_W-1:0] pend;
    logic              flush, we, commit, ovr;

    assign flush = fifo_clr || cfg_we;

    txcell_cfg #(.CELL_WORDS(CELL_WORDS), .CNT_W(CNT_W)) cfg_u (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hs_mode(cfg_hs_mode),
        .cfg_depth(cfg_depth), .mode_o(mode), .cap_o(cap));

    txcell_writer #(.CELL_WORDS(CELL_WORDS), .CNT_W(CNT_W), .PEND_W(PEND_W)) wr_u (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .tx_en(tx_en), .tx_soc(tx_soc),
        .irq_clr(irq_clr), .cap_i(cap), .used_i(used), .we_o(we), .waddr_o(waddr),
        .commit_o(commit), .ovr_o(ovr), .pend_o(pend), .irq_o(irq_ovr));

    txcell_store #(.DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .MEM_WORDS(MEM_WORDS),
                   .CNT_W(CNT_W), .PTR_W(PTR_W), .PEND_W(PEND_W)) st_u (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .cap_i(cap), .we_i(we),
        .waddr_i(waddr), .wdata_i(tx_data), .commit_i(commit), .rd_en(rd_en),
        .used_o(used), .rd_valid(rd_valid), .rd_sop(rd_sop), .rd_data(rd_data));

    // Space-available: word threshold or whole-cell rule, selected by the mode.
    always_comb begin
        free_w = cap - used - CNT_W'(pend);
        resv   = {1'b0, used} + ((pend != '0) ? (CNT_W + 1)'(CELL_WORDS) : '0);
        if (mode == HS_OCTET) tx_clav = (free_w > CNT_W'(OCTET_LOW_WRITES));
        else                  tx_clav = ({1'b0, cap} >= resv + (CNT_W + 1)'(CELL_WORDS));
    end

    // R9 R10
    clav_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_clav) |-> !ovr);
endmodule

// File: tb/txcell_fifo_top_tb_top.sv
// Scoreboard bench: driver tasks queue expected words, a monitor pops and compares reads.
module txcell_fifo_top_tb_top;
    localparam int DATA_W = 8;
    localparam int CW     = 53;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_hs_mode = 1'b0, fifo_clr = 1'b0;
    logic [1:0] cfg_depth = '0;
    logic tx_en = 1'b0, tx_soc = 1'b0, irq_clr = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] tx_data = '0;
    logic tx_clav, irq_ovr, rd_valid, rd_sop;
    logic [DATA_W-1:0] rd_data;

    int checks = 0, errors = 0;
    bit rd_allow = 1'b0;
    logic [DATA_W:0] exp_q[$];

    always #5 clk = ~clk;

    txcell_fifo_top #(.DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hs_mode(cfg_hs_mode),
        .cfg_depth(cfg_depth), .fifo_clr(fifo_clr), .tx_en(tx_en), .tx_soc(tx_soc),
        .tx_data(tx_data), .tx_clav(tx_clav), .irq_clr(irq_clr), .irq_ovr(irq_ovr),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_sop(rd_sop), .rd_data(rd_data));

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(input int id, input int i);
        return DATA_W'(id * 29 + i * 3 + 1);
    endfunction

    task automatic put_word(input bit soc, input logic [DATA_W-1:0] d);
        @(negedge clk);
        tx_en = 1'b1; tx_soc = soc; tx_data = d;
    endtask

    task automatic idle();
        @(negedge clk);
        tx_en = 1'b0; tx_soc = 1'b0;
    endtask

    // Words lo..hi-1 of cell id; queued as expected when the cell will commit.
    task automatic send_part(input int id, input int lo, input int hi, input bit expect_it);
        for (int i = lo; i < hi; i++) begin
            put_word(i == 0, pat(id, i));
            if (expect_it) exp_q.push_back({i == 0, pat(id, i)});
        end
    endtask

    task automatic cfg(input bit mode, input logic [1:0] dsel);
        @(negedge clk);
        cfg_we = 1'b1; cfg_hs_mode = mode; cfg_depth = dsel;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); fifo_clr = 1'b1;
        @(negedge clk); fifo_clr = 1'b0;
    endtask

    task automatic drain(input string tag);
        rd_allow = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(int'(rd_valid), 0, tag);
    endtask

    // Monitor: compare each presented word and its start flag with the queue head (R5).
    always @(negedge clk) begin
        rd_en <= 1'b0;
        if (rst_n && rd_allow && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected word actual %h expected none", rd_data);
            end else begin
                logic [DATA_W:0] e;
                e = exp_q.pop_front();
                if ({rd_sop, rd_data} != e) begin
                    errors++;
                    $display("FAIL R5 word actual %h expected %h", {rd_sop, rd_data}, e);
                end
            end
            rd_en <= 1'b1;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(int'(rd_valid), 0, "R1 rd_valid");
        chk(int'(irq_ovr), 0, "R1 irq");
        chk(int'(tx_clav), 1, "R1 clav");

        // R3 stray words before any start-of-cell are ignored; R6 runt dropped
        rd_allow = 1'b1;
        put_word(1'b0, 8'hAA); put_word(1'b0, 8'hBB);
        send_part(1, 0, CW, 1'b1);
        send_part(2, 0, CW, 1'b1);
        send_part(3, 0, 10, 1'b0);
        send_part(4, 0, CW, 1'b1);
        idle();
        drain("R6 runt left no data");

        // R4 nothing visible until the last word
        rd_allow = 1'b0;
        send_part(5, 0, CW - 1, 1'b1);
        idle();
        chk(int'(rd_valid), 0, "R4 partial hidden");
        send_part(5, CW - 1, CW, 1'b1);
        idle();
        chk(int'(rd_valid), 1, "R4 visible after commit");
        chk(int'(rd_sop), 1, "R5 first word flag");
        drain("R4 drained");

        // R1 default cell-level mode at 16 cells: 15 cells plus an open one leaves no cell
        rd_allow = 1'b0;
        for (int c = 0; c < 15; c++) send_part(10 + c, 0, CW, 1'b0);
        send_part(30, 0, 1, 1'b0);
        idle();
        chk(int'(tx_clav), 0, "R1 R10 default mode and depth");
        pulse_clr();
        chk(int'(rd_valid), 0, "R11 clear empties");
        chk(int'(tx_clav), 1, "R11 clav after clear");

        // R2 configuration write flushes stored cells
        send_part(31, 0, CW, 1'b0);
        idle();
        chk(int'(rd_valid), 1, "R2 data before cfg");
        cfg(1'b1, 2'd0);
        chk(int'(rd_valid), 0, "R2 cfg flush");

        // R10 cell-level, two cells deep
        chk(int'(tx_clav), 1, "R10 empty");
        send_part(32, 0, CW, 1'b0);
        idle();
        chk(int'(tx_clav), 1, "R10 one cell stored");
        send_part(33, 0, 1, 1'b0);
        idle();
        chk(int'(tx_clav), 0, "R10 open cell reserves last slot");
        pulse_clr();
        chk(int'(rd_valid), 0, "R11 clear drops cells");
        chk(int'(tx_clav), 1, "R11 clav restored");
        chk(int'(irq_ovr), 0, "R11 irq untouched");

        // R9 word-level threshold and R7 overrun, two cells deep
        cfg(1'b0, 2'd0);
        send_part(40, 0, CW, 1'b1);
        send_part(41, 0, 48, 1'b1);
        idle();
        chk(int'(tx_clav), 1, "R9 five words free");
        send_part(41, 48, 49, 1'b1);
        idle();
        chk(int'(tx_clav), 0, "R9 four words free");
        send_part(41, 49, CW, 1'b1);
        idle();
        chk(int'(irq_ovr), 0, "R7 full but no overrun yet");
        put_word(1'b1, 8'h55);
        put_word(1'b0, 8'h66); put_word(1'b0, 8'h77);
        idle();
        chk(int'(irq_ovr), 1, "R7 overrun flag");
        chk(int'(rd_valid), 1, "R7 committed cells kept");
        drain("R7 no damaged cell delivered");
        chk(int'(tx_clav), 1, "R9 clav back high");
        send_part(42, 0, CW, 1'b1);
        idle();
        drain("R7 resume after overrun");
        chk(int'(irq_ovr), 1, "R8 still set");
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk(int'(irq_ovr), 0, "R8 cleared");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule